// File: doc/BRIEF.md
# Request/Acknowledge Byte Handshake Port

This block moves a single byte between a host and a peripheral controller through a parallel shift register. A request/acknowledge handshake paces each transfer. The host starts a transfer with a one-cycle strobe: `send_go` writes the byte on `tx_byte`, and `recv_go` reads a byte into `rx_byte`. The block reports the end of the transfer with a one-cycle `done` pulse and a result code on `err_code`.

On the peripheral side the block drives an active-low request line `req_n`, a direction bit `dir_out` and the outgoing shift-register byte `sr_out`. It reads the incoming byte `sr_in` and samples `ack` through a two-flop synchroniser. Every wait for an acknowledge level has a limit of `TIMEOUT_MS` millisecond ticks. A divider produces one tick every `CLKS_PER_MS` clock cycles, and both the divider and the tick counter restart whenever the controller changes state.

The controller has five states. **IDLE** waits for a strobe (IDLE→READY_CHK). **READY_CHK** waits for acknowledge high: it goes to TX_HOLD for a send, to RX_REQ for a receive, or back to IDLE with an error on timeout. **TX_HOLD** holds request low: acknowledge low ends it (success, →IDLE), and a timeout ends it with an error (→IDLE). **RX_REQ** holds request low: acknowledge low leads to RX_AVAIL, and a timeout ends it with an error (→IDLE). **RX_AVAIL** has request high again: acknowledge high captures the byte (success, →IDLE), and a timeout ends it with an error (→IDLE).

Top module: `hs_byte_port`

## Requirements
- R1: After reset `req_n` is 1, `done` is 0, `err_code` is 0 and `dir_out` is 0 (input).
- R2: No transfer drives `req_n` low until the synchronised acknowledge has been seen high. If acknowledge stays low, the transfer fails by timeout and request never goes low.
- R3: A send sets `dir_out` to 1 and presents the byte latched at the strobe on `sr_out`. It then holds `req_n` low until acknowledge goes low, releases request, and finishes with `err_code` 0.
- R4: A receive sets `dir_out` to 0 and holds `req_n` low until acknowledge goes low. It then releases request, waits for acknowledge high, copies `sr_in` into `rx_byte`, and finishes with `err_code` 0.
- R5: Each acknowledge wait ends in failure after `TIMEOUT_MS`×`CLKS_PER_MS` cycles in that wait, plus at most three cycles of pipeline.
- R6: `err_code` is 0 for success, 1 for any send-side failure and 2 for any receive-side failure. It changes only when `done` pulses and holds its value until the next pulse.
- R7: Whenever `done` pulses, `req_n` is high. After a failure the block returns to IDLE and accepts a new strobe.
- R8: Strobes that arrive while a transfer is in progress are ignored. If both strobes arrive in the same cycle in IDLE, the send is taken.
- R9: `done` lasts exactly one cycle per transfer.
- R10: While `req_n` is low, `dir_out` and `sr_out` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| send_go | input | 1 | Strobe: start a send of `tx_byte` |
| recv_go | input | 1 | Strobe: start a receive |
| tx_byte | input | 8 | Byte to send, latched at the strobe |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_code | output | 2 | Result code: 0 ok, 1 send error, 2 receive error |
| rx_byte | output | 8 | Last byte received |
| req_n | output | 1 | Active-low request to the peripheral |
| dir_out | output | 1 | Shift-register direction, 1 = output |
| sr_out | output | 8 | Byte presented to the shift register |
| sr_in | input | 8 | Byte read from the shift register |
| ack | input | 1 | Acknowledge from the peripheral, asynchronous |

## Verification
The bench sweeps all 256 byte values through both sends and receives, with peripheral response delays that vary from byte to byte. A design that latched `sr_in` on the falling acknowledge edge, or that loaded `sr_out` late, would return wrong bytes. Four error cases are forced: acknowledge stuck low before a transfer, no response to the request, and acknowledge never rising again during a receive. These cases check the error code, the elapsed cycle count and that request stays high during the pre-check. A timer that did not restart per wait, or a code chosen by the failing state instead of the transfer kind, would show up there. Strobes sent mid-transfer and simultaneous strobes expose a controller that restarts or gives the wrong priority.

// File: rtl/hs_pkg.sv
package hs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READY_CHK,
        ST_TX_HOLD,
        ST_RX_REQ,
        ST_RX_AVAIL
    } hs_state_t;

    localparam logic [1:0] HS_OK       = 2'd0;
    localparam logic [1:0] HS_SEND_ERR = 2'd1;
    localparam logic [1:0] HS_RECV_ERR = 2'd2;
endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q_sync <= 1'b0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/hs_ms_tick.sv
module hs_ms_tick #(
    parameter int CLKS_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = $clog2(CLKS_PER_MS + 1);
    localparam logic [W-1:0] LAST = W'(CLKS_PER_MS - 1);

    logic [W-1:0] div_q;

    assign tick = (div_q == LAST) && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div_q <= '0;
        else if (clr || tick)    div_q <= '0;
        else                     div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/hs_wait_timer.sv
module hs_wait_timer #(
    parameter int TIMEOUT_MS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int W = $clog2(TIMEOUT_MS + 1);
    localparam logic [W-1:0] LIMIT = W'(TIMEOUT_MS);

    logic [W-1:0] ms_q;

    assign expired = (ms_q == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ms_q <= '0;
        else if (clr)                ms_q <= '0;
        else if (tick && !expired)   ms_q <= ms_q + 1'b1;
    end
endmodule

// File: rtl/hs_byte_port.sv
module hs_byte_port #(
    parameter int CLKS_PER_MS = 100000,
    parameter int TIMEOUT_MS  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       send_go,
    input  logic       recv_go,
    input  logic [7:0] tx_byte,
    output logic       done,
    output logic [1:0] err_code,
    output logic [7:0] rx_byte,
    output logic       req_n,
    output logic       dir_out,
    output logic [7:0] sr_out,
    input  logic [7:0] sr_in,
    input  logic       ack
);
    import hs_pkg::*;

    hs_state_t state_q, state_d;
    logic      ack_s;
    logic      tick;
    logic      expired;
    logic      wait_clr;
    logic      op_send_q;
    logic [7:0] tx_q;
    logic      fin, fin_fail;

    hs_sync2 u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ack),
        .q_sync  (ack_s)
    );

    assign wait_clr = (state_q == ST_IDLE) || (state_q != state_d);

    hs_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wait_clr),
        .tick  (tick)
    );

    hs_wait_timer #(.TIMEOUT_MS(TIMEOUT_MS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wait_clr),
        .tick    (tick),
        .expired (expired)
    );

    // next-state and completion decode
    always_comb begin
        state_d  = state_q;
        fin      = 1'b0;
        fin_fail = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (send_go || recv_go) state_d = ST_READY_CHK;
            end
            ST_READY_CHK: begin
                if (ack_s)        state_d = op_send_q ? ST_TX_HOLD : ST_RX_REQ;
                else if (expired) begin state_d = ST_IDLE; fin = 1'b1; fin_fail = 1'b1; end
            end
            ST_TX_HOLD: begin
                if (!ack_s)       begin state_d = ST_IDLE; fin = 1'b1; end
                else if (expired) begin state_d = ST_IDLE; fin = 1'b1; fin_fail = 1'b1; end
            end
            ST_RX_REQ: begin
                if (!ack_s)       state_d = ST_RX_AVAIL;
                else if (expired) begin state_d = ST_IDLE; fin = 1'b1; fin_fail = 1'b1; end
            end
            ST_RX_AVAIL: begin
                if (ack_s)        begin state_d = ST_IDLE; fin = 1'b1; end
                else if (expired) begin state_d = ST_IDLE; fin = 1'b1; fin_fail = 1'b1; end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign req_n = !((state_q == ST_TX_HOLD) || (state_q == ST_RX_REQ));

    // registered outputs and transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_send_q <= 1'b0;
            tx_q      <= '0;
            dir_out   <= 1'b0;
            sr_out    <= '0;
            rx_byte   <= '0;
            done      <= 1'b0;
            err_code  <= HS_OK;
        end else begin
            done <= fin;
            if (state_q == ST_IDLE && (send_go || recv_go)) begin
                op_send_q <= send_go;
                tx_q      <= tx_byte;
            end
            if (state_q == ST_READY_CHK && ack_s) begin
                dir_out <= op_send_q;
                if (op_send_q) sr_out <= tx_q;
            end
            if (state_q == ST_RX_AVAIL && ack_s) rx_byte <= sr_in;
            if (fin) begin
                if (!fin_fail)      err_code <= HS_OK;
                else if (op_send_q) err_code <= HS_SEND_ERR;
                else                err_code <= HS_RECV_ERR;
            end
        end
    end
endmodule

// File: rtl/hs_byte_port_chk.sv
module hs_byte_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic [1:0] err_code,
    input logic       req_n,
    input logic       dir_out,
    input logic [7:0] sr_out,
    input logic       ack_s
);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_req_released_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_n);

    assert_req_after_ack_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> $past(ack_s));

    assert_dir_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && $past(!req_n)) |-> $stable(dir_out));

    assert_data_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && $past(!req_n)) |-> $stable(sr_out));

    assert_code_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(err_code));
endmodule

bind hs_byte_port hs_byte_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .err_code (err_code),
    .req_n    (req_n),
    .dir_out  (dir_out),
    .sr_out   (sr_out),
    .ack_s    (ack_s)
);

// File: tb/test_hs_byte_port.sv
`timescale 1ns/100ps
module test_hs_byte_port;
    localparam int C = 4;
    localparam int T = 32;
    localparam int TO = T * C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic send_go = 1'b0, recv_go = 1'b0;
    logic [7:0] tx_byte = '0;
    logic done;
    logic [1:0] err_code;
    logic [7:0] rx_byte;
    logic req_n, dir_out;
    logic [7:0] sr_out;
    logic [7:0] sr_in;
    logic ack;

    int checks = 0, fails = 0, cycles = 0;

    hs_byte_port #(.CLKS_PER_MS(C), .TIMEOUT_MS(T)) i_hs_byte_port (
        .clk(clk), .rst_n(rst_n), .send_go(send_go), .recv_go(recv_go),
        .tx_byte(tx_byte), .done(done), .err_code(err_code), .rx_byte(rx_byte),
        .req_n(req_n), .dir_out(dir_out), .sr_out(sr_out), .sr_in(sr_in), .ack(ack)
    );

    always #2.5 clk = ~clk;

    // peripheral model: 0 normal, 1 ack stuck low, 2 ack stuck high, 3 ack never returns high
    int mode = 0;
    int dly = 0;
    logic [7:0] rx_val = '0;
    logic [7:0] seen = '0;
    logic seen_dir = 1'b0;
    int pcnt = 0;
    logic mon_clr = 1'b0;
    logic req_low_seen = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b1; sr_in <= '0; pcnt <= 0;
        end else if (mode == 1) begin
            ack <= 1'b0; pcnt <= 0;
        end else if (mode == 2) begin
            ack <= 1'b1; pcnt <= 0;
        end else if (ack && !req_n) begin
            if (pcnt >= dly) begin
                ack <= 1'b0; pcnt <= 0; seen <= sr_out; seen_dir <= dir_out;
            end else pcnt <= pcnt + 1;
        end else if (!ack && req_n && mode == 0) begin
            if (pcnt >= dly) begin
                ack <= 1'b1; sr_in <= rx_val; pcnt <= 0;
            end else pcnt <= pcnt + 1;
        end else pcnt <= 0;
    end

    always @(posedge clk) begin
        if (mon_clr) req_low_seen <= 1'b0;
        else if (!req_n) req_low_seen <= 1'b1;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            checks = checks + 1; fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            summary();
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic s, input logic r, input logic [7:0] b);
        @(negedge clk);
        send_go = s; recv_go = r; tx_byte = b;
        @(negedge clk);
        send_go = 1'b0; recv_go = 1'b0;
    endtask

    // counts negedges from the strobe edge until done is seen
    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc = cyc + 1;
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    int cyc;
    int extra;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_n == 1'b1, "R1 req_n", req_n, 1);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(err_code == 2'd0, "R1 err_code", err_code, 0);
        chk(dir_out == 1'b0, "R1 dir_out", dir_out, 0);
        settle();

        // R3 sweep of all byte values through sends
        for (int b = 0; b < 256; b++) begin
            mode = 0; dly = b % 5;
            strobe(1'b1, 1'b0, 8'(b));
            wait_done(cyc);
            chk(err_code == 2'd0, "R3 send code", err_code, 0);
            chk(req_n == 1'b1, "R7 req at done", req_n, 1);
            chk(seen == 8'(b), "R3 sent byte", seen, b);
            chk(seen_dir == 1'b1, "R3 direction", seen_dir, 1);
            @(negedge clk);
            chk(done == 1'b0, "R9 pulse width", done, 0);
            settle();
        end

        // R4 sweep of all byte values through receives
        for (int b = 0; b < 256; b++) begin
            mode = 0; dly = (b * 3) % 7; rx_val = 8'(255 - b);
            strobe(1'b0, 1'b1, 8'h00);
            wait_done(cyc);
            chk(err_code == 2'd0, "R4 recv code", err_code, 0);
            chk(rx_byte == 8'(255 - b), "R4 recv byte", rx_byte, 255 - b);
            chk(dir_out == 1'b0, "R4 direction", dir_out, 0);
            settle();
        end

        // R2 ack stuck low: send fails in pre-check, request never asserted
        mode = 1; repeat (6) @(negedge clk);
        mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
        strobe(1'b1, 1'b0, 8'hA5);
        wait_done(cyc);
        chk(err_code == 2'd1, "R6 precheck send code", err_code, 1);
        chk(!req_low_seen, "R2 no request", req_low_seen, 0);
        chk(cyc >= TO && cyc <= TO + 3, "R5 precheck window", cyc, TO + 1);
        settle();
        mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
        strobe(1'b0, 1'b1, 8'h00);
        wait_done(cyc);
        chk(err_code == 2'd2, "R6 precheck recv code", err_code, 2);
        chk(!req_low_seen, "R2 no request recv", req_low_seen, 0);
        settle();

        // R5 ack never falls during send; R8 mid-transfer receive strobe ignored
        mode = 2; repeat (6) @(negedge clk);
        strobe(1'b1, 1'b0, 8'h3C);
        repeat (20) @(negedge clk);
        strobe(1'b0, 1'b1, 8'h00);
        wait_done(cyc);
        cyc = cyc + 22;
        chk(err_code == 2'd1, "R8 busy strobe ignored code", err_code, 1);
        chk(cyc >= TO && cyc <= TO + 3, "R5 send wait window", cyc, TO + 2);
        chk(req_n == 1'b1, "R7 req released after error", req_n, 1);
        extra = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, "R8 no second transfer", extra, 0);

        // R5 receive never sees ack return high
        mode = 3; dly = 1;
        strobe(1'b0, 1'b1, 8'h00);
        wait_done(cyc);
        chk(err_code == 2'd2, "R6 recv avail timeout code", err_code, 2);
        chk(req_n == 1'b1, "R7 req high after recv error", req_n, 1);
        mode = 0; settle();

        // R8 simultaneous strobes: send wins; R7 recovery after errors
        mode = 0; dly = 2;
        strobe(1'b1, 1'b1, 8'h96);
        wait_done(cyc);
        chk(err_code == 2'd0, "R8 both strobes code", err_code, 0);
        chk(seen == 8'h96, "R8 send taken", seen, 8'h96);
        chk(dir_out == 1'b1, "R8 direction out", dir_out, 1);
        settle();

        summary();
    end
endmodule